// File: doc/BRIEF.md
# Dual-Role LCD Segment/Common Driver

This block is the digital part of an 80-output LCD driver. Two mode pins choose its role. As a segment driver, it gathers one display line through a shift path that advances on a data clock, taking either a nibble or a single bit per pulse. The whole line is moved into an output latch on the falling edge of a separate latch clock. As a common driver, the same 80 register stages form a scan chain. The scan bit advances one stage per rising edge of the latch clock, and the data clock is ignored.

Every output carries a 2-bit code that selects one of four bias levels. The code depends on the output's bit, the frame-inversion input and the role. A display-off input forces every output to the lowest level. All clock inputs are sampled and edge-detected in the single system clock domain. A direction input sets which end of the register takes new data. Cascade pins carry an enable forward in segment role and carry the scan bit in common role.

Top module: `lcd_seg_com_drv`

## Requirements
- R1: After reset, the shift register, the output latch and the fill count are zero, so in segment role with the inversion input at 0 every output code is 2'b10.
- R2: Mode {mode_com_i, mode_alt_i}=00 is segment role with nibble input. With dir_i=0, the nibble taken on pulse k (k=0..19) ends at bits 79-4k down to 76-4k after 20 pulses, with din_i[3] at the higher index. With dir_i=1, it ends at bits 4k+3 down to 4k.
- R3: Mode 01 is segment role with bit input from din_i[0]. With dir_i=0, the bit taken on pulse k (k=0..79) ends at index 79-k. With dir_i=1, it ends at index k.
- R4: In segment role, a data clock pulse while en_i is low changes neither the register nor the fill count.
- R5: en_o rises once a full line has been taken in (20 pulses in nibble mode, 80 in bit mode). Further data clock pulses are then ignored. A latch-clock falling edge clears the count, and with it en_o.
- R6: In segment role, the output latch loads the register only on a falling edge of lclk_i. Before that edge the outputs keep showing the previous line.
- R7: Modes 10 and 11 are common role. Each rising edge of lclk_i shifts scan_i in: at index 0 moving upward when dir_i=0, and at index 79 moving downward when dir_i=1. Data clock pulses have no effect. The outputs follow the register directly.
- R8: In mode 11, the register acts as two 40-stage chains (indices 0..39 and 40..79). Both take scan_i on the same edge, each at the end that dir_i selects.
- R9: While dispoff_ni is low, every output code is 2'b00, whatever the mode or data.
- R10: Level codes are 00=V0, 01=V12, 10=V34, 11=V5. In segment role: bit 1 gives 00 when m_i=0 and 11 when m_i=1; bit 0 gives 10 when m_i=0 and 01 when m_i=1.
- R11: In common role: bit 1 gives 11 when m_i=0 and 00 when m_i=1; bit 0 gives 01 when m_i=0 and 10 when m_i=1.
- R12: scan_o is register bit 79 when dir_i=0 and bit 0 when dir_i=1, so a scan bit reaches it after 80 edges in mode 10 and after 40 edges in mode 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_com_i | input | 1 | 1 selects common role, 0 segment role |
| mode_alt_i | input | 1 | Segment: 1 = bit input, 0 = nibble input. Common: 1 = dual chain, 0 = single chain |
| dir_i | input | 1 | Shift direction |
| dclk_i | input | 1 | Data clock (segment role) |
| lclk_i | input | 1 | Latch clock in segment role, shift clock in common role |
| en_i | input | 1 | Cascade enable in (segment role) |
| din_i | input | 4 | Display data; bit 0 alone is used in bit mode |
| scan_i | input | 1 | Scan bit in (common role) |
| m_i | input | 1 | Frame-inversion signal |
| dispoff_ni | input | 1 | Active-low display off |
| en_o | output | 1 | Cascade enable out, high when the line is full |
| scan_o | output | 1 | Scan bit out for the next device |
| lvl_o | output | 160 | Level code per output, output i at bits 2i+1:2i |

## Verification
The assertions check four properties on every cycle. The latch stays stable without a falling latch edge. The register and count freeze while en_i is low, and also, in common role, when no rising latch edge arrives. The fill count never runs past the line length. Display-off forces zero codes. Only the bench's scenarios can show where each nibble or bit lands for both directions and both input widths. They also show the exact pulse on which en_o rises, the one-hot and two-hot scan patterns at every step, and the full level encoding against the inversion input.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

  typedef enum logic [1:0] {
    LV_V0  = 2'b00,
    LV_V12 = 2'b01,
    LV_V34 = 2'b10,
    LV_V5  = 2'b11
  } lvl_e;

  // p flips with role and frame; set bit drives {p,p}, clear bit {~p,p}
  function automatic logic [1:0] sel_level(input logic com, input logic m, input logic d);
    logic p;
    p = m ^ com;
    return d ? {p, p} : {~p, p};
  endfunction

endpackage

// File: rtl/lcd_edge_det.sv
module lcd_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
  assign fall_o = ~sig_i & sig_q;
endmodule

// File: rtl/lcd_shift_core.sv
module lcd_shift_core #(
  parameter int unsigned NUM_OUT = 80,
  parameter int unsigned PAR_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               com_i,
  input  logic               alt_i,
  input  logic               dir_i,
  input  logic               dclk_rise_i,
  input  logic               lclk_rise_i,
  input  logic               lclk_fall_i,
  input  logic               en_i,
  input  logic [PAR_W-1:0]   din_i,
  input  logic               scan_i,
  output logic [NUM_OUT-1:0] sr_o,
  output logic               en_o,
  output logic               scan_o
);
  localparam int unsigned HALF  = NUM_OUT / 2;
  localparam int unsigned PAR_N = NUM_OUT / PAR_W;
  localparam int unsigned CNT_W = $clog2(NUM_OUT + 1);

  logic [NUM_OUT-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d, full_cnt;
  logic               seg_shift;
  logic [HALF-1:0]    lo_h, hi_h;

  assign full_cnt  = alt_i ? CNT_W'(NUM_OUT) : CNT_W'(PAR_N);
  assign seg_shift = !com_i && dclk_rise_i && en_i && (cnt_q != full_cnt);
  assign lo_h      = sr_q[HALF-1:0];
  assign hi_h      = sr_q[NUM_OUT-1:HALF];

  always_comb begin
    sr_d = sr_q;
    if (com_i) begin
      if (lclk_rise_i) begin
        if (alt_i) begin
          if (dir_i) sr_d = {scan_i, hi_h[HALF-1:1], scan_i, lo_h[HALF-1:1]};
          else       sr_d = {hi_h[HALF-2:0], scan_i, lo_h[HALF-2:0], scan_i};
        end else begin
          if (dir_i) sr_d = {scan_i, sr_q[NUM_OUT-1:1]};
          else       sr_d = {sr_q[NUM_OUT-2:0], scan_i};
        end
      end
    end else if (seg_shift) begin
      if (alt_i) begin
        if (dir_i) sr_d = {din_i[0], sr_q[NUM_OUT-1:1]};
        else       sr_d = {sr_q[NUM_OUT-2:0], din_i[0]};
      end else begin
        if (dir_i) sr_d = {din_i, sr_q[NUM_OUT-1:PAR_W]};
        else       sr_d = {sr_q[NUM_OUT-1-PAR_W:0], din_i};
      end
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (com_i || lclk_fall_i) cnt_d = '0;
    else if (seg_shift)       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign sr_o   = sr_q;
  assign en_o   = !com_i && (cnt_q == full_cnt);
  assign scan_o = dir_i ? sr_q[0] : sr_q[NUM_OUT-1];

  AST_NO_SHIFT_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!com_i && !en_i && !lclk_fall_i) |=> ($stable(sr_q) && $stable(cnt_q))); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(NUM_OUT)); // R5
  AST_COM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (com_i && !lclk_rise_i) |=> $stable(sr_q)); // R7
endmodule

// File: rtl/lcd_level_enc.sv
module lcd_level_enc #(
  parameter int unsigned NUM_OUT = 80
) (
  input  logic                 com_i,
  input  logic                 m_i,
  input  logic                 dispoff_ni,
  input  logic [NUM_OUT-1:0]   bits_i,
  output logic [2*NUM_OUT-1:0] lvl_o
);
  import lcd_drv_pkg::*;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    assign lvl_o[2*i +: 2] = dispoff_ni ? sel_level(com_i, m_i, bits_i[i]) : LV_V0;
  end
endmodule

// File: rtl/lcd_seg_com_drv.sv
module lcd_seg_com_drv #(
  parameter int unsigned NUM_OUT = 80,
  parameter int unsigned PAR_W   = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_com_i,
  input  logic                 mode_alt_i,
  input  logic                 dir_i,
  input  logic                 dclk_i,
  input  logic                 lclk_i,
  input  logic                 en_i,
  input  logic [PAR_W-1:0]     din_i,
  input  logic                 scan_i,
  input  logic                 m_i,
  input  logic                 dispoff_ni,
  output logic                 en_o,
  output logic                 scan_o,
  output logic [2*NUM_OUT-1:0] lvl_o
);
  logic               dclk_rise, dclk_fall, lclk_rise, lclk_fall;
  logic [NUM_OUT-1:0] sr, latch_q, shown;

  lcd_edge_det i_dclk_edge (
    .clk_i, .rst_ni, .sig_i(dclk_i), .rise_o(dclk_rise), .fall_o(dclk_fall)
  );
  lcd_edge_det i_lclk_edge (
    .clk_i, .rst_ni, .sig_i(lclk_i), .rise_o(lclk_rise), .fall_o(lclk_fall)
  );

  lcd_shift_core #(.NUM_OUT(NUM_OUT), .PAR_W(PAR_W)) i_core (
    .clk_i, .rst_ni,
    .com_i(mode_com_i), .alt_i(mode_alt_i), .dir_i,
    .dclk_rise_i(dclk_rise), .lclk_rise_i(lclk_rise), .lclk_fall_i(lclk_fall),
    .en_i, .din_i, .scan_i,
    .sr_o(sr), .en_o, .scan_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       latch_q <= '0;
    else if (!mode_com_i && lclk_fall) latch_q <= sr;
  end

  // common role drives outputs straight from the scan chain
  assign shown = mode_com_i ? sr : latch_q;

  lcd_level_enc #(.NUM_OUT(NUM_OUT)) i_enc (
    .com_i(mode_com_i), .m_i, .dispoff_ni, .bits_i(shown), .lvl_o
  );

  logic unused_edge;
  assign unused_edge = dclk_fall;

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_com_i || !lclk_fall) |=> $stable(latch_q)); // R6
  AST_DISPOFF_V0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dispoff_ni |-> (lvl_o == '0)); // R9
endmodule

// File: tb/test_lcd_seg_com_drv.sv
module test_lcd_seg_com_drv;
  localparam int N = 80;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_com, mode_alt, dir, dclk, lclk, en, scan, m, dispoff_n;
  logic [W-1:0] din;
  logic en_o, scan_o;
  logic [2*N-1:0] lvl_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lcd_seg_com_drv #(.NUM_OUT(N), .PAR_W(W)) i_lcd_seg_com_drv (
    .clk_i(clk), .rst_ni, .mode_com_i(mode_com), .mode_alt_i(mode_alt), .dir_i(dir),
    .dclk_i(dclk), .lclk_i(lclk), .en_i(en), .din_i(din), .scan_i(scan), .m_i(m),
    .dispoff_ni(dispoff_n), .en_o, .scan_o, .lvl_o
  );

  function automatic logic [1:0] code(input logic com, input logic mm, input logic d);
    if (!com) return d ? (mm ? 2'd3 : 2'd0) : (mm ? 2'd1 : 2'd2);
    else      return d ? (mm ? 2'd0 : 2'd3) : (mm ? 2'd2 : 2'd1);
  endfunction

  function automatic logic [2*N-1:0] expand(input logic [N-1:0] b, input logic com,
                                            input logic mm, input logic on);
    logic [2*N-1:0] r;
    for (int i = 0; i < N; i++) r[2*i +: 2] = on ? code(com, mm, b[i]) : 2'b00;
    return r;
  endfunction

  task automatic chk_vec(input string req, input logic [2*N-1:0] got, input logic [2*N-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_d(input logic [W-1:0] v);
    din = v; dclk = 1'b1;
    @(negedge clk); dclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_l();
    lclk = 1'b1;
    @(negedge clk); lclk = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [N-1:0] exp_b, prev_b;
    mode_com = 0; mode_alt = 0; dir = 0; dclk = 0; lclk = 0; en = 1;
    scan = 0; m = 0; dispoff_n = 1; din = '0;
    do_reset();
    chk_vec("R1 reset", lvl_o, expand('0, 1'b0, 1'b0, 1'b1));
    chk_bit("R1 en_o reset", en_o, 1'b0);
    prev_b = '0;

    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 2; s++) begin
        dir = d[0]; mode_alt = s[0]; m = 0;
        exp_b = '0;
        if (s == 0) begin
          for (int k = 0; k < N / W; k++) begin
            logic [W-1:0] nib;
            nib = W'((k * 7 + 3 + d) & 15);
            if (d == 0) exp_b[(N - 1 - W * k) -: W] = nib;
            else        exp_b[(W * k) +: W] = nib;
            if (k == N / W - 1) chk_bit("R5 en_o before last nibble", en_o, 1'b0);
            pulse_d(nib);
          end
        end else begin
          for (int k = 0; k < N; k++) begin
            logic bt;
            bt = logic'((((k * 5) >> 2) ^ k ^ d) & 1);
            if (d == 0) exp_b[N - 1 - k] = bt;
            else        exp_b[k] = bt;
            if (k == N - 1) chk_bit("R5 en_o before last bit", en_o, 1'b0);
            pulse_d({W{bt}});
          end
        end
        chk_bit("R5 en_o full", en_o, 1'b1);
        pulse_d('1);
        chk_vec("R6 before latch", lvl_o, expand(prev_b, 1'b0, 1'b0, 1'b1));
        lclk = 1'b1;
        @(negedge clk);
        chk_vec("R6 lclk high no load", lvl_o, expand(prev_b, 1'b0, 1'b0, 1'b1));
        lclk = 1'b0;
        @(negedge clk);
        chk_vec(s ? "R3 serial fill" : "R2 nibble fill", lvl_o, expand(exp_b, 1'b0, 1'b0, 1'b1));
        chk_bit("R5 en_o cleared", en_o, 1'b0);
        m = 1;
        @(negedge clk);
        chk_vec("R10 segment m=1", lvl_o, expand(exp_b, 1'b0, 1'b1, 1'b1));
        en = 0;
        for (int k = 0; k < 5; k++) pulse_d(W'(k + 9));
        pulse_l();
        chk_vec("R4 disabled pulses ignored", lvl_o, expand(exp_b, 1'b0, 1'b1, 1'b1));
        en = 1;
        dispoff_n = 0;
        @(negedge clk);
        chk_vec("R9 display off segment", lvl_o, '0);
        dispoff_n = 1;
        prev_b = exp_b;
      end
    end

    mode_com = 1;
    for (int dual = 0; dual < 2; dual++) begin
      for (int d = 0; d < 2; d++) begin
        int len;
        len = dual ? N / 2 : N;
        mode_alt = dual[0]; dir = d[0];
        do_reset();
        scan = 1;
        pulse_l();
        scan = 0;
        for (int k = 0; k < len; k++) begin
          exp_b = '0;
          if (d == 0) begin
            exp_b[k] = 1'b1;
            if (dual == 1) exp_b[k + N / 2] = 1'b1;
          end else begin
            exp_b[N - 1 - k] = 1'b1;
            if (dual == 1) exp_b[N / 2 - 1 - k] = 1'b1;
          end
          m = logic'(k & 1);
          @(negedge clk);
          chk_vec(dual ? "R8 dual scan R11" : "R7 single scan R11", lvl_o,
                  expand(exp_b, 1'b1, m, 1'b1));
          if (k >= len - 2) chk_bit("R12 scan_o", scan_o, logic'(k == len - 1));
          pulse_d('1);
          pulse_l();
        end
      end
    end
    dispoff_n = 0;
    @(negedge clk);
    chk_vec("R9 display off common", lvl_o, '0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule